// File: doc/BRIEF.md
# Transmit Mode-Code Descriptor Control Word

This block keeps the 16-bit control word that a command/response serial-bus remote terminal consults when it answers transmit mode-code commands. A command is one of these when its transmit bit is set and its subaddress is all zeros or all ones. The host programs the word through a small register port. It chooses between ping-pong and indexed single buffering, arms two kinds of interrupt, and can ask the device to suspend ping-pong buffering for a while. The terminal's execution logic reports each finished command through a one-cycle strobe that carries the decoded fields.

On each qualifying completion the block updates its device-owned status bits. These are an accessed flag, a ping-pong-on acknowledge, a broadcast flag and the current-buffer pointer. It can also raise one-cycle interrupt requests, each tagged by its position in a type vector for an external pending-interrupt register. A host read returns the word and then clears the accessed flag. A software reset clears only part of the status.

Word layout:
- Bit 15: access-interrupt arm.
- Bits 14 and 13: spare host bits.
- Bit 12: index-zero interrupt arm.
- Bit 11: accessed.
- Bit 10: ping-pong on.
- Bit 9: broadcast.
- Bit 8: buffer pointer.
- Bit 3: suspend request.
- Bit 2: buffer mode (1 = ping-pong, 0 = indexed).
- All other bits read 0.

Top module: `mcd_ctrl_word`

## Requirements
- R1: With `rst_n` low at a clock edge, the word, `host_rdata` and `irq_req` all become 0.
- R2: A host write changes bits 15, 14, 13, 12 and 3 at all times. It changes bit 2 only while `exec_en` is 0. It never changes bits 11 to 8, 7 to 4, 1 or 0, and the unused bits read 0.
- R3: A completion strobe counts only when `exec_en` is 1, `cmd_tx` is 1 and `cmd_sa` is 0 or 31. Any other strobe leaves the word and `irq_req` unchanged.
- R4: Each counted completion sets bit 11. A host read clears bit 11 after returning it. When a read and a counted completion fall in the same cycle, the read returns the old word and bit 11 ends up set.
- R5: A `soft_rst` pulse clears bits 11, 9 and 8 and leaves every other bit as it was.
- R6: At each counted completion, bit 9 takes the value of `cmd_bcast`.
- R7: At a counted completion, bit 8 toggles if bit 2 and bit 10 were both 1 before that completion; otherwise bit 8 holds.
- R8: Bit 10 changes only at a counted completion. It then becomes bit 2 AND NOT bit 3, so a suspend or re-enable request is acknowledged at the next completion.
- R9: `irq_req[0]` (type access) is high for exactly the one cycle after a counted completion, and only when `gl_acc_irq_en` and bit 15 are both 1.
- R10: `irq_req[1]` (type index-zero) is high for the one cycle after a counted completion, and only when bit 2 is 0, `cmd_idx` equals 1, and `gl_izero_irq_en` and bit 12 are both 1.
- R11: `host_rdata` shows the word as it stood in the cycle `host_rd` was high, from the next edge onwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low master reset |
| soft_rst | input | 1 | Software reset pulse (partial clear) |
| exec_en | input | 1 | Terminal execution enabled |
| host_wr | input | 1 | Host write strobe |
| host_wdata | input | 16 | Host write data |
| host_rd | input | 1 | Host read strobe |
| host_rdata | output | 16 | Registered read data |
| cmd_done | input | 1 | Command-complete strobe |
| cmd_tx | input | 1 | Transmit bit of the completed command |
| cmd_sa | input | 5 | Subaddress of the completed command |
| cmd_bcast | input | 1 | Completed command was broadcast |
| cmd_idx | input | 8 | Index count before this command's decrement |
| gl_acc_irq_en | input | 1 | Global enable for access interrupts |
| gl_izero_irq_en | input | 1 | Global enable for index-zero interrupts |
| ctl_word | output | 16 | Current control word |
| irq_req | output | 2 | One-cycle interrupt requests, bit 0 access, bit 1 index-zero |

## Verification
Every result of this block is due one clock edge after its stimulus. The word bits move at the edge that samples a write, a completion or a reset. `host_rdata` and `irq_req` are registered, so they appear at that same edge. The bench drives each stimulus at a falling edge and compares at the next falling edge, half a period after the deciding rising edge. It also looks again one cycle later to confirm that each interrupt pulse has dropped.

// File: rtl/mcd_pkg.sv
// Package: shared widths, bit positions and interrupt type codes for the
// mode-code descriptor control word. Assumes a 16-bit word.
package mcd_pkg;
    localparam int unsigned CW_W = 16;

    // host-owned fields
    localparam int unsigned B_ACC_IE  = 15;
    localparam int unsigned B_SPARE1  = 14;
    localparam int unsigned B_SPARE0  = 13;
    localparam int unsigned B_IZ_IE   = 12;
    localparam int unsigned B_SUSP    = 3;
    localparam int unsigned B_MODE    = 2;
    // device-owned fields
    localparam int unsigned B_ACCESSD = 11;
    localparam int unsigned B_PPON    = 10;
    localparam int unsigned B_BCAST   = 9;
    localparam int unsigned B_PTR     = 8;

    // bits the host may write at any time
    localparam logic [CW_W-1:0] HOST_ANY_MASK =
        (CW_W'(1) << B_ACC_IE) | (CW_W'(1) << B_SPARE1) |
        (CW_W'(1) << B_SPARE0) | (CW_W'(1) << B_IZ_IE) |
        (CW_W'(1) << B_SUSP);
    // bits the host may write only while execution is off
    localparam logic [CW_W-1:0] HOST_IDLE_MASK = CW_W'(1) << B_MODE;

    // interrupt type codes: position in the request vector
    typedef enum logic [0:0] {
        IRQ_ACCESS   = 1'b0,
        IRQ_IDX_ZERO = 1'b1
    } irq_kind_e;
    localparam int unsigned IRQ_KINDS = 2;
endpackage

// File: rtl/mcd_cmd_qual.sv
// Command qualifier: decides whether a completion strobe belongs to this
// descriptor (transmit, mode-code subaddress, execution on).
// Assumes the mode-code subaddresses are all-zeros and all-ones.
module mcd_cmd_qual #(
    parameter int unsigned SA_W = 5
) (
    input  logic            done,
    input  logic            tx,
    input  logic [SA_W-1:0] sa,
    input  logic            exec_en,
    output logic            hit
);
    localparam logic [SA_W-1:0] SA_LO = '0;
    localparam logic [SA_W-1:0] SA_HI = '1;

    logic sa_mode;

    // subaddress match on either mode-code value
    always_comb begin
        sa_mode = (sa == SA_LO) || (sa == SA_HI);
    end

    // final qualification of the strobe
    always_comb begin
        hit = done && tx && exec_en && sa_mode;
    end
endmodule

// File: rtl/mcd_host_regs.sv
// Host-owned bits of the control word. The write mask depends on the bit
// and on execution state. Assumes single-cycle write strobes; only master
// reset clears these bits.
module mcd_host_regs
    import mcd_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            exec_en,
    input  logic            wr_en,
    input  logic [CW_W-1:0] wr_data,
    output logic [CW_W-1:0] host_bits
);
    logic [CW_W-1:0] wmask;
    logic [CW_W-1:0] host_q;

    // writable set for this cycle
    always_comb begin
        wmask = HOST_ANY_MASK | (exec_en ? '0 : HOST_IDLE_MASK);
    end

    // masked host register update
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            host_q <= '0;
        end else if (wr_en) begin
            host_q <= (host_q & ~wmask) | (wr_data & wmask);
        end
    end

    assign host_bits = host_q;

    a_r2_mode_locked_exec: assert property (@(posedge clk) disable iff (!rst_n)
        exec_en |=> $stable(host_q[B_MODE]));
    a_r2_no_write_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(host_q));
endmodule

// File: rtl/mcd_dev_status.sv
// Device-owned status bits: accessed flag, ping-pong acknowledge,
// broadcast flag and buffer pointer. Assumes `hit` is a qualified
// completion. Software reset wins over a completion in the same cycle,
// and a completion wins over a host read clear.
module mcd_dev_status (
    input  logic clk,
    input  logic rst_n,
    input  logic soft_rst,
    input  logic hit,
    input  logic cmd_bcast,
    input  logic pp_mode,
    input  logic susp_req,
    input  logic rd_clear,
    output logic accessed,
    output logic pp_on,
    output logic bcast,
    output logic ptr
);
    logic acc_q, bc_q, ptr_q, ppon_q;

    // accessed flag: set by completion, cleared by read or soft reset
    always_ff @(posedge clk) begin
        if (!rst_n || soft_rst) begin
            acc_q <= 1'b0;
        end else if (hit) begin
            acc_q <= 1'b1;
        end else if (rd_clear) begin
            acc_q <= 1'b0;
        end
    end

    // broadcast flag and buffer pointer
    always_ff @(posedge clk) begin
        if (!rst_n || soft_rst) begin
            bc_q  <= 1'b0;
            ptr_q <= 1'b0;
        end else if (hit) begin
            bc_q <= cmd_bcast;
            if (pp_mode && ppon_q) begin
                ptr_q <= ~ptr_q;
            end
        end
    end

    // ping-pong acknowledge, moved only at completion
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ppon_q <= 1'b0;
        end else if (hit) begin
            ppon_q <= pp_mode && !susp_req;
        end
    end

    assign accessed = acc_q;
    assign pp_on    = ppon_q;
    assign bcast    = bc_q;
    assign ptr      = ptr_q;

    a_r4_acc_after_hit: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && !soft_rst) |=> accessed);
    a_r8_ppon_only_on_hit: assert property (@(posedge clk) disable iff (!rst_n)
        !hit |=> $stable(pp_on));
    a_r7_ptr_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        ((!hit || !pp_on) && !soft_rst) |=> $stable(ptr));
    a_r5_srst_clears: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> (!accessed && !bcast && !ptr));
endmodule

// File: rtl/mcd_irq_gen.sv
// Interrupt request generator: one registered single-cycle pulse per type,
// indexed by mcd_pkg::irq_kind_e. Assumes cmd_idx is the index before the
// decrement of this command, so a value of 1 means it reaches zero now.
module mcd_irq_gen
    import mcd_pkg::*;
#(
    parameter int unsigned IDX_W = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 hit,
    input  logic                 pp_mode,
    input  logic [IDX_W-1:0]     cmd_idx,
    input  logic                 gl_acc_en,
    input  logic                 gl_iz_en,
    input  logic                 acc_arm,
    input  logic                 iz_arm,
    output logic [IRQ_KINDS-1:0] irq_req
);
    localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(1);

    logic [IRQ_KINDS-1:0] cause;
    logic [IRQ_KINDS-1:0] irq_q;

    // per-type cause terms
    always_comb begin
        cause = '0;
        cause[IRQ_ACCESS]   = hit && gl_acc_en && acc_arm;
        cause[IRQ_IDX_ZERO] = hit && !pp_mode && (cmd_idx == IDX_LAST)
                              && gl_iz_en && iz_arm;
    end

    // one register stage per type
    for (genvar k = 0; k < IRQ_KINDS; k++) begin : g_irq
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                irq_q[k] <= 1'b0;
            end else begin
                irq_q[k] <= cause[k];
            end
        end
    end

    assign irq_req = irq_q;

    a_r9_acc_cause: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req[IRQ_ACCESS] |-> $past(hit && gl_acc_en && acc_arm));
    a_r10_iz_cause: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req[IRQ_IDX_ZERO] |-> $past(hit && !pp_mode && cmd_idx == IDX_LAST));
endmodule

// File: rtl/mcd_ctrl_word.sv
// Top: transmit mode-code descriptor control word. It assembles the word
// from host and device fields and provides the registered host read with
// its accessed-flag clear. Assumes single-cycle host strobes; reset is
// synchronous and active low.
module mcd_ctrl_word
    import mcd_pkg::*;
#(
    parameter int unsigned SA_W  = 5,
    parameter int unsigned IDX_W = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 soft_rst,
    input  logic                 exec_en,
    input  logic                 host_wr,
    input  logic [CW_W-1:0]      host_wdata,
    input  logic                 host_rd,
    output logic [CW_W-1:0]      host_rdata,
    input  logic                 cmd_done,
    input  logic                 cmd_tx,
    input  logic [SA_W-1:0]      cmd_sa,
    input  logic                 cmd_bcast,
    input  logic [IDX_W-1:0]     cmd_idx,
    input  logic                 gl_acc_irq_en,
    input  logic                 gl_izero_irq_en,
    output logic [CW_W-1:0]      ctl_word,
    output logic [IRQ_KINDS-1:0] irq_req
);
    logic            hit;
    logic [CW_W-1:0] host_bits;
    logic            st_acc, st_ppon, st_bc, st_ptr;
    logic [CW_W-1:0] word;
    logic [CW_W-1:0] rdata_q;

    mcd_cmd_qual #(.SA_W(SA_W)) u_qual (
        .done    (cmd_done),
        .tx      (cmd_tx),
        .sa      (cmd_sa),
        .exec_en (exec_en),
        .hit     (hit)
    );

    mcd_host_regs u_host (
        .clk       (clk),
        .rst_n     (rst_n),
        .exec_en   (exec_en),
        .wr_en     (host_wr),
        .wr_data   (host_wdata),
        .host_bits (host_bits)
    );

    mcd_dev_status u_dev (
        .clk       (clk),
        .rst_n     (rst_n),
        .soft_rst  (soft_rst),
        .hit       (hit),
        .cmd_bcast (cmd_bcast),
        .pp_mode   (host_bits[B_MODE]),
        .susp_req  (host_bits[B_SUSP]),
        .rd_clear  (host_rd),
        .accessed  (st_acc),
        .pp_on     (st_ppon),
        .bcast     (st_bc),
        .ptr       (st_ptr)
    );

    mcd_irq_gen #(.IDX_W(IDX_W)) u_irq (
        .clk       (clk),
        .rst_n     (rst_n),
        .hit       (hit),
        .pp_mode   (host_bits[B_MODE]),
        .cmd_idx   (cmd_idx),
        .gl_acc_en (gl_acc_irq_en),
        .gl_iz_en  (gl_izero_irq_en),
        .acc_arm   (host_bits[B_ACC_IE]),
        .iz_arm    (host_bits[B_IZ_IE]),
        .irq_req   (irq_req)
    );

    // merge host and device fields into the visible word
    always_comb begin
        word = host_bits;
        word[B_ACCESSD] = st_acc;
        word[B_PPON]    = st_ppon;
        word[B_BCAST]   = st_bc;
        word[B_PTR]     = st_ptr;
    end

    // registered host read data
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata_q <= '0;
        end else if (host_rd) begin
            rdata_q <= word;
        end
    end

    assign ctl_word   = word;
    assign host_rdata = rdata_q;

    a_r11_rdata_capture: assert property (@(posedge clk) disable iff (!rst_n)
        host_rd |=> (host_rdata == $past(ctl_word)));
    a_r3_irq_needs_exec: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_req != '0) |-> $past(exec_en && cmd_tx));
endmodule

// File: tb/mcd_ctrl_word_tb.sv
// Bench: sweeps host writes, command fields, index values and handshake
// states against a bench-side model built from the requirements.
module mcd_ctrl_word_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        soft_rst = 1'b0;
    logic        exec_en = 1'b0;
    logic        host_wr = 1'b0;
    logic [15:0] host_wdata = '0;
    logic        host_rd = 1'b0;
    logic [15:0] host_rdata;
    logic        cmd_done = 1'b0;
    logic        cmd_tx = 1'b0;
    logic [4:0]  cmd_sa = '0;
    logic        cmd_bcast = 1'b0;
    logic [7:0]  cmd_idx = '0;
    logic        gl_acc = 1'b0;
    logic        gl_iz = 1'b0;
    logic [15:0] ctl_word;
    logic [1:0]  irq_req;

    int n_chk = 0;
    int n_fail = 0;
    bit ended = 0;

    // model state
    logic [15:0] m_host = '0;
    logic m_acc = 0, m_pp = 0, m_bc = 0, m_ptr = 0;

    always #10 clk = ~clk;

    mcd_ctrl_word dut_i (
        .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .exec_en(exec_en),
        .host_wr(host_wr), .host_wdata(host_wdata), .host_rd(host_rd),
        .host_rdata(host_rdata), .cmd_done(cmd_done), .cmd_tx(cmd_tx),
        .cmd_sa(cmd_sa), .cmd_bcast(cmd_bcast), .cmd_idx(cmd_idx),
        .gl_acc_irq_en(gl_acc), .gl_izero_irq_en(gl_iz),
        .ctl_word(ctl_word), .irq_req(irq_req)
    );

    function automatic logic [15:0] exp_word();
        logic [15:0] w;
        w = m_host;
        w[11] = m_acc; w[10] = m_pp; w[9] = m_bc; w[8] = m_ptr;
        return w;
    endfunction

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic host_write(input logic [15:0] d);
        logic [15:0] m;
        @(negedge clk);
        host_wr = 1'b1; host_wdata = d;
        @(negedge clk);
        host_wr = 1'b0;
        m = 16'hF008 | (exec_en ? 16'h0000 : 16'h0004);
        m_host = (m_host & ~m) | (d & m);
        chk("R2 write mask", ctl_word, exp_word());
    endtask

    task automatic host_read();
        logic [15:0] e;
        @(negedge clk);
        host_rd = 1'b1;
        e = exp_word();
        @(negedge clk);
        host_rd = 1'b0;
        chk("R11 read data", host_rdata, e);
        m_acc = 0;
        chk("R4 read clears accessed", ctl_word, exp_word());
        chk("R9 R10 no pulse", {14'd0, irq_req}, 16'd0);
    endtask

    task automatic do_cmd(input logic tx, input logic [4:0] sa, input logic bc, input logic [7:0] idx);
        logic v, e_a, e_z;
        @(negedge clk);
        cmd_done = 1'b1; cmd_tx = tx; cmd_sa = sa; cmd_bcast = bc; cmd_idx = idx;
        v   = exec_en && tx && (sa == 5'd0 || sa == 5'd31);
        e_a = v && gl_acc && m_host[15];
        e_z = v && !m_host[2] && idx == 8'd1 && gl_iz && m_host[12];
        if (v) begin
            m_acc = 1; m_bc = bc;
            if (m_host[2] && m_pp) m_ptr = ~m_ptr;
            m_pp = m_host[2] && !m_host[3];
        end
        @(negedge clk);
        cmd_done = 1'b0;
        chk("R3 R6 R7 R8 word after completion", ctl_word, exp_word());
        chk("R9 R10 irq pulse", {14'd0, irq_req}, {14'd0, e_z, e_a});
    endtask

    // watchdog
    initial begin
        repeat (100000) @(posedge clk);
        if (!ended) begin
            n_fail++; n_chk++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 word", ctl_word, 16'h0000);
        chk("R1 rdata", host_rdata, 16'h0000);
        chk("R1 irq", {14'd0, irq_req}, 16'd0);
        rst_n = 1'b1;

        // R2 write sweep, execution off and on
        for (int e = 0; e < 2; e++) begin
            exec_en = e[0];
            for (int b = 0; b < 16; b++) host_write(16'h1 << b);
            host_write(16'hFFFF);
            host_write(16'h0000);
        end

        // R3 gating sweep with access interrupt armed
        exec_en = 1'b0;
        host_write(16'h8000);
        gl_acc = 1'b1;
        do_cmd(1'b1, 5'd0, 1'b1, 8'd0);         // R3 ignored while exec off
        exec_en = 1'b1;
        for (int t = 0; t < 2; t++) begin
            for (int s = 0; s < 32; s++) begin
                do_cmd(t[0], s[4:0], s[0], 8'd3);
                host_read();
            end
        end
        gl_acc = 1'b0;
        do_cmd(1'b1, 5'd31, 1'b0, 8'd0);         // R9 global enable off

        // R7 R8 ping-pong handshake sweep
        exec_en = 1'b0;
        host_write(16'h0004);
        exec_en = 1'b1;
        for (int i = 0; i < 12; i++) begin
            if (i == 5) host_write(16'h0008 | m_host);  // suspend request
            if (i == 8) host_write(m_host & ~16'h0008); // re-enable
            do_cmd(1'b1, (i % 2) ? 5'd31 : 5'd0, i[1], 8'd0);
        end

        // R10 index sweep in indexed mode
        exec_en = 1'b0;
        host_write(16'h1000);
        exec_en = 1'b1;
        for (int g = 0; g < 2; g++) begin
            for (int a = 0; a < 2; a++) begin
                gl_iz = g[0];
                host_write(a[0] ? 16'h1000 : 16'h0000);
                for (int x = 0; x < 4; x++) do_cmd(1'b1, 5'd0, 1'b0, 8'(x));
            end
        end
        // R10 no pulse in ping-pong mode
        exec_en = 1'b0;
        host_write(16'h1004);
        exec_en = 1'b1;
        do_cmd(1'b1, 5'd0, 1'b0, 8'd1);

        // R5 software reset
        do_cmd(1'b1, 5'd0, 1'b1, 8'd0);
        do_cmd(1'b1, 5'd0, 1'b1, 8'd0);
        host_write(m_host | 16'h6008);
        @(negedge clk);
        soft_rst = 1'b1;
        @(negedge clk);
        soft_rst = 1'b0;
        m_acc = 0; m_bc = 0; m_ptr = 0;
        chk("R5 partial clear", ctl_word, exp_word());

        // R4 read and completion in the same cycle
        @(negedge clk);
        host_rd = 1'b1; cmd_done = 1'b1; cmd_tx = 1'b1; cmd_sa = 5'd0; cmd_bcast = 1'b0;
        begin
            logic [15:0] e0;
            e0 = exp_word();
            @(negedge clk);
            host_rd = 1'b0; cmd_done = 1'b0;
            m_acc = 1; m_bc = 0;
            if (m_host[2] && m_pp) m_ptr = ~m_ptr;
            m_pp = m_host[2] && !m_host[3];
            chk("R4 read returns old word", host_rdata, e0);
            chk("R4 completion wins", ctl_word, exp_word());
        end

        // R1 master reset mid-run
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        m_host = '0; m_acc = 0; m_pp = 0; m_bc = 0; m_ptr = 0;
        chk("R1 master reset word", ctl_word, 16'h0000);
        chk("R1 master reset rdata", host_rdata, 16'h0000);

        ended = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule